// File: doc/BRIEF.md
# Flash Erase/Program Sequencer

This block sits on the host side of a parallel NOR flash device and turns single erase or word-program requests into the command cycles the device expects. A request arrives over a valid/ready handshake with an operation type, an address and a data word. The sequencer writes the setup and confirm cycles and polls the device status byte until the device reports ready. It then decodes the status byte in a fixed priority order, clears the status on any error, returns the device to array mode and reports a result code with a one-cycle done pulse.

An erase or program that is still running can be paused. When the host raises the suspend input, the sequencer sends the suspend command and waits for the device to settle. It then tells a real suspension apart from an operation that finished first. A suspended operation is restarted with the resume input. For batches, the host can skip the status check on individual requests and check only the last one, because the device keeps error flags until they are cleared. A poll budget limits how long the sequencer waits on a device that never becomes ready.

Top module: `flash_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0, susp_active is 0, fl_ce_n, fl_we_n and fl_oe_n are 1 and fl_dq_oe is 0.
- R2: An erase request (req_op=0) writes 20H and then D0H, both at the request address. It then reads the status byte repeatedly, while the byte's bit 7 is 0.
- R3: A program request (req_op=1) writes 40H at the request address and then writes req_data at the same address. It then polls status bit 7 in the same way.
- R4: Every bus cycle holds fl_ce_n low for exactly PULSE_CYC clocks, with fl_we_n low for a write or fl_oe_n low for a read, never both. fl_addr and fl_dq_o do not change while fl_ce_n is low.
- R5: When the full check is requested (req_full_chk=1), the status byte is decoded in this order. Bit 3 set gives code 1. Otherwise bit 1 set gives code 2. Otherwise, for an erase, bits 5 and 4 both set give code 3. Otherwise bit 5 (erase) or bit 4 (program) set gives code 4. Otherwise the code is 0.
- R6: A non-zero code from R5 makes the sequencer write 50H and then FFH; a zero code writes FFH only. done is then high for one clock with the code on err_code, and req_ready is 1 in the next clock.
- R7: With req_full_chk=0, done comes with code 0 as soon as status bit 7 reads 1, and no further bus write follows. Error bits left set on the device are reported by a later checked request.
- R8: If susp_req is 1 when a status read shows bit 7 = 0, the sequencer writes B0H and polls. If the suspended flag is then 1 (bit 6 for erase, bit 2 for program), susp_active goes to 1. While suspended, no bus cycle and no done occur.
- R9: While suspended, resume_req=1 makes the sequencer write D0H, drop susp_active and return to status polling. The request then completes as in R5 and R6.
- R10: If the suspended flag reads 0 after the suspend command, no D0H is written and susp_active stays 0. The request completes as in R5 and R6.
- R11: After TMO_POLLS consecutive status reads with bit 7 = 0, done is given with code 5 and no further bus write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 1 | 0 = block erase, 1 = word program |
| req_addr | input | AW | Target address (any address in the block for erase) |
| req_data | input | DW | Program data |
| req_full_chk | input | 1 | 1 = decode status and recover; 0 = batch, report on ready |
| susp_req | input | 1 | Suspend the running operation |
| resume_req | input | 1 | Resume a suspended operation |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 voltage, 2 protect, 3 sequence, 4 operation, 5 timeout |
| susp_active | output | 1 | Operation is suspended |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash status byte read lane |

## Verification
The hardest case to reach from the ports is the suspend command arriving after the device has already finished. In that case the ready bit reads 1 while the suspended flag reads 0, and the sequencer must skip the resume. The bench's device model has a switch that makes it finish its operation at the moment it receives B0H, so this race comes out the same on every run. A second switch keeps the model busy forever, which drives the poll budget to its limit. Error bits are injected only when an operation completes, so leftover flags from an unchecked batch request show up on the next checked one.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_VPP    = 3'd1,
    ERR_PROT   = 3'd2,
    ERR_SEQ    = 3'd3,
    ERR_OPFAIL = 3'd4,
    ERR_TMO    = 3'd5
  } fs_err_e;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_CLR_STAT    = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EFAIL = 5;
  localparam int SB_PFAIL = 4;
  localparam int SB_VPP   = 3;
  localparam int SB_PSUSP = 2;
  localparam int SB_PROT  = 1;

endpackage

// File: rtl/flash_bus_cyc.sv
module flash_bus_cyc #(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int PULSE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i
);

  localparam int CW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PULSE, PH_RECOV} ph_e;

  ph_e           ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rd_q, rd_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic [7:0]    rdata_q, rdata_d;
  logic          last_beat;

  assign last_beat = (ph_q == PH_PULSE) && (cnt_q == '0);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    data_d  = data_q;
    rdata_d = rdata_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_PULSE;
          cnt_d  = CW'(PULSE_CYC - 1);
          rd_d   = rd;
          addr_d = addr;
          data_d = wdata;
        end
      end
      PH_PULSE: begin
        if (cnt_q == '0) ph_d = PH_RECOV;
        else             cnt_d = cnt_q - 1'b1;
      end
      PH_RECOV: ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
    if (last_beat && rd_q) rdata_d = fl_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign done     = (ph_q == PH_RECOV);
  assign rdata    = rdata_q;
  assign fl_ce_n  = (ph_q != PH_PULSE);
  assign fl_we_n  = !((ph_q == PH_PULSE) && !rd_q);
  assign fl_oe_n  = !((ph_q == PH_PULSE) && rd_q);
  assign fl_addr  = addr_q;
  assign fl_dq_o  = data_q;
  assign fl_dq_oe = (ph_q != PH_IDLE) && !rd_q;

  // Low-run counter for the strobe width check
  logic [CW:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (!fl_ce_n) low_run_q <= low_run_q + 1'b1;
    else               low_run_q <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R4

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o))); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_ce_n) |-> (low_run_q == (CW+1)'(PULSE_CYC))); // R4

endmodule

// File: rtl/flash_stat_dec.sv
module flash_stat_dec
  import flash_seq_pkg::*;
(
  input  logic    is_prog,
  input  logic    st_vpp,
  input  logic    st_prot,
  input  logic    st_efail,
  input  logic    st_pfail,
  output fs_err_e code
);

  always_comb begin
    if (st_vpp)                             code = ERR_VPP;
    else if (st_prot)                       code = ERR_PROT;
    else if (!is_prog && st_efail && st_pfail) code = ERR_SEQ;
    else if (is_prog ? st_pfail : st_efail) code = ERR_OPFAIL;
    else                                    code = ERR_NONE;
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int PULSE_CYC = 3,
  parameter int TMO_POLLS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_full_chk,
  input  logic          susp_req,
  input  logic          resume_req,
  output logic          done,
  output logic [2:0]    err_code,
  output logic          susp_active,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_i
);

  localparam int PW = $clog2(TMO_POLLS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_CONF, S_PRD, S_PEVAL, S_SUSW, S_SRD,
    S_SEVAL, S_HALT, S_RESW, S_CLR, S_RDA, S_DONE
  } st_e;

  function automatic logic [DW-1:0] to_bus(input logic [7:0] c);
    logic [DW-1:0] r;
    r      = '0;
    r[7:0] = c;
    return r;
  endfunction

  st_e           st_q, st_d;
  logic          op_q, op_d;
  logic          chk_q, chk_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  fs_err_e       err_q, err_d;
  logic [PW-1:0] poll_q, poll_d;

  logic          bus_start, bus_rd, bus_busy, bus_done;
  logic [DW-1:0] bus_wdata;
  logic [7:0]    bus_rdata;
  fs_err_e       dec_code;
  fs_err_e       fin_err;
  st_e           fin_st;
  logic          susp_flag, tmo_hit, go;
  logic          stat_unused;

  flash_bus_cyc #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (bus_start),
    .rd       (bus_rd),
    .addr     (addr_q),
    .wdata    (bus_wdata),
    .busy     (bus_busy),
    .done     (bus_done),
    .rdata    (bus_rdata),
    .fl_ce_n  (fl_ce_n),
    .fl_we_n  (fl_we_n),
    .fl_oe_n  (fl_oe_n),
    .fl_addr  (fl_addr),
    .fl_dq_o  (fl_dq_o),
    .fl_dq_oe (fl_dq_oe),
    .fl_dq_i  (fl_dq_i)
  );

  flash_stat_dec u_dec (
    .is_prog  (op_q),
    .st_vpp   (bus_rdata[SB_VPP]),
    .st_prot  (bus_rdata[SB_PROT]),
    .st_efail (bus_rdata[SB_EFAIL]),
    .st_pfail (bus_rdata[SB_PFAIL]),
    .code     (dec_code)
  );

  assign stat_unused = bus_rdata[0];
  assign go          = !bus_busy;
  assign susp_flag   = op_q ? bus_rdata[SB_PSUSP] : bus_rdata[SB_ESUSP];
  assign tmo_hit     = (poll_q == PW'(TMO_POLLS - 1));
  assign fin_err     = chk_q ? dec_code : ERR_NONE;
  assign fin_st      = !chk_q ? S_DONE : ((dec_code != ERR_NONE) ? S_CLR : S_RDA);

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    chk_d     = chk_q;
    addr_d    = addr_q;
    data_d    = data_q;
    err_d     = err_q;
    poll_d    = poll_q;
    bus_start = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          op_d   = req_op;
          addr_d = req_addr;
          data_d = req_data;
          chk_d  = req_full_chk;
          err_d  = ERR_NONE;
          st_d   = S_SETUP;
        end
      end
      S_SETUP: begin
        bus_start = go;
        bus_wdata = to_bus(op_q ? CMD_PROG_SETUP : CMD_ERASE_SETUP);
        if (bus_done) st_d = S_CONF;
      end
      S_CONF: begin
        bus_start = go;
        bus_wdata = op_q ? data_q : to_bus(CMD_CONFIRM);
        if (bus_done) begin
          poll_d = '0;
          st_d   = S_PRD;
        end
      end
      S_PRD: begin
        bus_start = go;
        bus_rd    = 1'b1;
        if (bus_done) st_d = S_PEVAL;
      end
      S_PEVAL: begin
        if (bus_rdata[SB_READY]) begin
          err_d = fin_err;
          st_d  = fin_st;
        end else if (tmo_hit) begin
          err_d = ERR_TMO;
          st_d  = S_DONE;
        end else begin
          poll_d = poll_q + 1'b1;
          st_d   = susp_req ? S_SUSW : S_PRD;
        end
      end
      S_SUSW: begin
        bus_start = go;
        bus_wdata = to_bus(CMD_SUSPEND);
        if (bus_done) st_d = S_SRD;
      end
      S_SRD: begin
        bus_start = go;
        bus_rd    = 1'b1;
        if (bus_done) st_d = S_SEVAL;
      end
      S_SEVAL: begin
        if (bus_rdata[SB_READY]) begin
          if (susp_flag) begin
            st_d = S_HALT;
          end else begin
            err_d = fin_err;
            st_d  = fin_st;
          end
        end else if (tmo_hit) begin
          err_d = ERR_TMO;
          st_d  = S_DONE;
        end else begin
          poll_d = poll_q + 1'b1;
          st_d   = S_SRD;
        end
      end
      S_HALT: begin
        if (resume_req) st_d = S_RESW;
      end
      S_RESW: begin
        bus_start = go;
        bus_wdata = to_bus(CMD_CONFIRM);
        if (bus_done) begin
          poll_d = '0;
          st_d   = S_PRD;
        end
      end
      S_CLR: begin
        bus_start = go;
        bus_wdata = to_bus(CMD_CLR_STAT);
        if (bus_done) st_d = S_RDA;
      end
      S_RDA: begin
        bus_start = go;
        bus_wdata = to_bus(CMD_READ_ARRAY);
        if (bus_done) st_d = S_DONE;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= 1'b0;
      chk_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= ERR_NONE;
      poll_q <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      chk_q  <= chk_d;
      addr_q <= addr_d;
      data_q <= data_d;
      err_q  <= err_d;
      poll_q <= poll_d;
    end
  end

  assign req_ready   = (st_q == S_IDLE);
  assign done        = (st_q == S_DONE);
  assign err_code    = err_q;
  assign susp_active = (st_q == S_HALT);

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && !fl_dq_oe)); // R1

  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done)); // R6

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    susp_active |-> (fl_ce_n && !done)); // R8

  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code <= 3'd5)); // R5

endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int PULSE = 3;
  localparam int TMO = 64;
  localparam int ERASE_T = 60;
  localparam int PROG_T = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_ready, req_op, req_full_chk;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          susp_req, resume_req;
  logic          done, susp_active;
  logic [2:0]    err_code;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o;
  logic [7:0]    fl_dq_i;

  flash_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PULSE), .TMO_POLLS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_full_chk(req_full_chk),
    .susp_req(susp_req), .resume_req(resume_req),
    .done(done), .err_code(err_code), .susp_active(susp_active),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  bit saw_susp = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // ---------------- device model ----------------
  logic [15:0]   log_q[$];
  logic [AW-1:0] alog_q[$];
  logic [7:0] inj = 8'h00;
  bit late = 1'b0, hang = 1'b0, flush = 1'b0;
  bit m_active = 1'b0, m_susp = 1'b0, m_prog = 1'b0;
  int m_cnt = 0, m_pend = 0;
  logic [7:0] m_err = 8'h00;
  logic we_prev = 1'b1;

  assign fl_dq_i = {!(m_active && !m_susp), m_susp && !m_prog, m_err[5:3],
                    m_susp && m_prog, m_err[1], 1'b0};

  always @(negedge clk) begin
    if (flush) begin
      m_active = 1'b0;
      m_susp = 1'b0;
    end
    if (!we_prev && fl_we_n) begin
      log_q.push_back(fl_dq_o);
      alog_q.push_back(fl_addr);
      if (m_pend == 2) begin
        m_active = 1'b1; m_prog = 1'b1; m_cnt = PROG_T; m_pend = 0;
      end else if (m_pend == 1) begin
        if (fl_dq_o[7:0] == 8'hD0) begin
          m_active = 1'b1; m_prog = 1'b0; m_cnt = ERASE_T;
        end
        m_pend = 0;
      end else begin
        case (fl_dq_o[7:0])
          8'h20: m_pend = 1;
          8'h40: m_pend = 2;
          8'h50: m_err = 8'h00;
          8'hB0: if (m_active && !m_susp) begin
                   if (late) begin m_active = 1'b0; m_err = m_err | inj; end
                   else m_susp = 1'b1;
                 end
          8'hD0: if (m_susp) m_susp = 1'b0;
          default: ;
        endcase
      end
    end
    we_prev = fl_we_n;
    if (m_active && !m_susp && !hang) begin
      if (m_cnt <= 1) begin m_active = 1'b0; m_err = m_err | inj; end
      else m_cnt--;
    end
  end

  // ---------------- bus cycle monitor (R4) ----------------
  int low_len = 0;
  bit bad = 1'b0;
  logic [AW-1:0] a_prev;
  logic [DW-1:0] d_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_ce_n) begin
        if (low_len > 0 && (fl_addr !== a_prev || fl_dq_o !== d_prev)) bad = 1'b1;
        if (!fl_we_n && !fl_oe_n) bad = 1'b1;
        if (fl_we_n && fl_oe_n) bad = 1'b1;
        low_len++;
        a_prev = fl_addr;
        d_prev = fl_dq_o;
      end else if (low_len > 0) begin
        chk("R4 strobe width/stability", {bad, 31'(low_len)}, {1'b0, 31'(PULSE)});
        low_len = 0;
        bad = 1'b0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [2:0] exp_q[$];
  string      tag_q[$];
  always @(negedge clk) begin
    if (susp_active) saw_susp = 1'b1;
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected done", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), 32'(err_code), 32'(exp_q.pop_front()));
      end
      done_cnt++;
    end
  end

  task automatic do_req(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic fc, input logic [2:0] exp, input string tag);
    log_q.delete();
    alog_q.delete();
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_full_chk = fc;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_log(input string req, input logic [15:0] e[$]);
    chk({req, " log length"}, 32'(log_q.size()), 32'(e.size()));
    foreach (e[i]) begin
      if (i < log_q.size()) chk({req, " log entry"}, 32'(log_q[i]), 32'(e[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..R11 act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] e[$];
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_addr = '0; req_data = '0;
    req_full_chk = 1'b1; susp_req = 1'b0; resume_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 susp_active", 32'(susp_active), 32'd0);
    chk("R1 strobes", {29'd0, fl_ce_n, fl_we_n, fl_oe_n}, 32'h7);
    chk("R1 dq_oe", 32'(fl_dq_oe), 32'd0);

    // R2 clean erase
    do_req(1'b0, 20'h1A000, 16'h0000, 1'b1, 3'd0, "R2 erase ok code");
    wait_done(1);
    e = '{16'h0020, 16'h00D0, 16'h00FF}; chk_log("R2 R6", e);
    chk("R2 setup addr", 32'(alog_q[0]), 32'h1A000);
    chk("R2 confirm addr", 32'(alog_q[1]), 32'h1A000);

    // R3 clean program
    do_req(1'b1, 20'h00345, 16'h5A3C, 1'b1, 3'd0, "R3 program ok code");
    wait_done(2);
    e = '{16'h0040, 16'h5A3C, 16'h00FF}; chk_log("R3", e);
    chk("R3 data addr", 32'(alog_q[1]), 32'h00345);

    // R5 priority cases
    inj = 8'h28;
    do_req(1'b0, 20'h20000, 16'h0, 1'b1, 3'd1, "R5 voltage code");
    wait_done(3);
    e = '{16'h0020, 16'h00D0, 16'h0050, 16'h00FF}; chk_log("R6 clear then array", e);
    inj = 8'h32;
    do_req(1'b0, 20'h20000, 16'h0, 1'b1, 3'd2, "R5 protect code");
    wait_done(4);
    inj = 8'h30;
    do_req(1'b0, 20'h20000, 16'h0, 1'b1, 3'd3, "R5 sequence code");
    wait_done(5);
    inj = 8'h30;
    do_req(1'b1, 20'h00010, 16'h1111, 1'b1, 3'd4, "R5 program bits5+4 code");
    wait_done(6);
    inj = 8'h20;
    do_req(1'b0, 20'h30000, 16'h0, 1'b1, 3'd4, "R5 erase fail code");
    wait_done(7);
    inj = 8'h10;
    do_req(1'b1, 20'h00020, 16'h2222, 1'b1, 3'd4, "R5 program fail code");
    wait_done(8);

    // R7 batch: unchecked then checked
    inj = 8'h10;
    do_req(1'b1, 20'h00030, 16'h3333, 1'b0, 3'd0, "R7 unchecked code");
    wait_done(9);
    e = '{16'h0040, 16'h3333}; chk_log("R7 no trailing writes", e);
    inj = 8'h00;
    do_req(1'b1, 20'h00031, 16'h4444, 1'b1, 3'd4, "R7 accumulated flag code");
    wait_done(10);
    e = '{16'h0040, 16'h4444, 16'h0050, 16'h00FF}; chk_log("R7 checked", e);

    // R8 / R9 suspend and resume
    do_req(1'b0, 20'h40000, 16'h0, 1'b1, 3'd0, "R9 resumed erase code");
    susp_req = 1'b1;
    while (!susp_active) @(negedge clk);
    susp_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 susp_active held", 32'(susp_active), 32'd1);
    chk("R8 no done while suspended", 32'(done_cnt), 32'd10);
    chk("R8 bus quiet", 32'(fl_ce_n), 32'd1);
    e = '{16'h0020, 16'h00D0, 16'h00B0}; chk_log("R8", e);
    resume_req = 1'b1;
    while (susp_active) @(negedge clk);
    resume_req = 1'b0;
    chk("R9 susp_active dropped", 32'(susp_active), 32'd0);
    wait_done(11);
    e = '{16'h0020, 16'h00D0, 16'h00B0, 16'h00D0, 16'h00FF}; chk_log("R9", e);

    // R10 suspend after completion
    late = 1'b1;
    saw_susp = 1'b0;
    do_req(1'b0, 20'h50000, 16'h0, 1'b1, 3'd0, "R10 late suspend code");
    susp_req = 1'b1;
    wait_done(12);
    susp_req = 1'b0;
    late = 1'b0;
    chk("R10 never suspended", 32'(saw_susp), 32'd0);
    e = '{16'h0020, 16'h00D0, 16'h00B0, 16'h00FF}; chk_log("R10 no resume", e);

    // R11 timeout
    hang = 1'b1;
    do_req(1'b0, 20'h60000, 16'h0, 1'b1, 3'd5, "R11 timeout code");
    wait_done(13);
    e = '{16'h0020, 16'h00D0}; chk_log("R11 no trailing writes", e);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    hang = 1'b0;
    chk("R11 ready after timeout", 32'(req_ready), 32'd1);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule